// File: doc/BRIEF.md
# Meter serial command and readout slave

This block is the slave end of a two-wire serial link between a host microcontroller and a measurement front end. The host drives the clock and frames each transaction with start and stop conditions on a shared open-drain data line. Every byte is followed by a ninth acknowledge bit. A write transaction loads four control bytes into configuration registers that the front end decodes. A read transaction returns ten bytes: a status flag byte followed by the slow, fast and two auxiliary conversion words.

The link sees no analog circuits. Conversion results come in on parallel inputs together with a one-cycle done strobe. The strobe raises a data-ready output that tells the host fresh results are waiting. Both bus lines are oversampled by the system clock through a synchronizer, and every protocol event is decoded in that clock domain.

Top module: `meter_link_slave`

## Requirements
- R1: After reset, `ctrl_word` is 0, `buzz_en` is 0, `data_ready` is 0 and `sda_oe` is 0, so the line is released.
- R2: An address byte is sent MSB first. It is the header 110010, then a buzzer bit, then a direction bit (0 = write, 1 = read). The slave acknowledges a matching address byte by pulling the line low during the ninth clock.
- R3: A write transaction carries four control bytes and the slave acknowledges each one. Control byte k (k = 1..4) is stored in `ctrl_word[8*(4-k)+7 -: 8]`, so the first byte lands in bits 31:24. The configuration outputs change only while the clock is low.
- R4: Any accepted address byte copies its buzzer bit to `buzz_en`. An address byte followed directly by a stop condition leaves `ctrl_word` unchanged.
- R5: An address byte with the wrong header is not acknowledged. The slave then ignores the bus until the next start condition, and does not acknowledge a valid-looking byte sent in that time.
- R6: A fifth or later control byte in a write transaction is not acknowledged and is not stored.
- R7: A `conv_done` pulse sets `data_ready` on the next clock. `data_ready` stays high through write transactions and stays high until a read address byte is accepted.
- R8: `data_ready` goes low when a read address byte is acknowledged. It stays low until the next `conv_done`.
- R9: The read bytes come out MSB first. Byte 1 is `res_flags`. Let P = {5'b0, res_aux1, res_aux0, res_fast, res_slow}, 72 bits wide. Read byte k (k = 2..10) is P[8*(10-k)+7 -: 8].
- R10: The read data is a snapshot taken when the read address byte is acknowledged. Input changes and conversions after that point do not alter the bytes of that transaction.
- R11: When the host sends a not-acknowledge after a read byte, the slave releases the line. It drives nothing more until the next start condition.
- R12: The slave changes the data line only while the clock is low. It samples incoming bits on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock from the host |
| sda_in | input | 1 | Level of the shared data line |
| sda_oe | output | 1 | Pull the data line low when 1 |
| conv_done | input | 1 | One-cycle strobe: new results are on the inputs |
| res_flags | input | 8 | Status flag byte: signs, battery level, alarm |
| res_slow | input | 19 | Slow, high-resolution conversion magnitude |
| res_fast | input | 10 | Fast, low-resolution conversion magnitude |
| res_aux0 | input | 19 | First auxiliary result word |
| res_aux1 | input | 19 | Second auxiliary result word |
| data_ready | output | 1 | Results waiting for the host |
| ctrl_word | output | 32 | Four stored control bytes |
| buzz_en | output | 1 | Buzzer enable from the last accepted address byte |

## Verification
Most internal faults reach the ports within one byte time. A miscounted bit or a wrong state shows up as a missing or misplaced acknowledge on the ninth clock, or as a read byte shifted by one position. That byte is compared in the same transaction. A snapshot taken at the wrong moment shows as old and new data mixed in one read, because the bench changes the inputs mid-transfer. A faulty data-ready set or clear shows at the output one clock after the strobe, or at the acknowledge of the read header.

// File: rtl/meter_link_pkg.sv
package meter_link_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_HDR, ST_HACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
   } link_state_t;

   localparam logic [5:0] HDR_CODE = 6'b110010;
endpackage

// File: rtl/meter_link_sync.sv
module meter_link_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_lvl
);
   if (STAGES < 2) begin : g_bad_stages
      $error("meter_link_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_chain, sda_chain;
   logic              scl_q, sda_q, scl_lvl;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_chain[i] <= 1'b1;
            sda_chain[i] <= 1'b1;
         end else if (i == 0) begin
            scl_chain[i] <= scl_in;
            sda_chain[i] <= sda_in;
         end else begin
            scl_chain[i] <= scl_chain[(i == 0) ? 0 : i-1];
            sda_chain[i] <= sda_chain[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign scl_lvl = scl_chain[STAGES-1];
   assign sda_lvl = sda_chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_lvl;
         sda_q <= sda_lvl;
      end
   end

   assign scl_rise  = scl_lvl & ~scl_q;
   assign scl_fall  = ~scl_lvl & scl_q;
   assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/meter_link_regs.sv
module meter_link_regs #(
   parameter int NBYTES = 4,
   parameter int IDXW   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDXW-1:0]   wr_idx,
   input  logic [7:0]        wr_data,
   input  logic              buzz_we,
   input  logic              buzz_val,
   output logic [NBYTES*8-1:0] ctrl_word,
   output logic              buzz_en
);
   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl_word[8*(NBYTES-1-i) +: 8] <= 8'h00;
         else if (wr_en && wr_idx == IDXW'(i))
            ctrl_word[8*(NBYTES-1-i) +: 8] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buzz_en <= 1'b0;
      else if (buzz_we) buzz_en <= buzz_val;
   end
endmodule

// File: rtl/meter_link_fsm.sv
module meter_link_fsm
   import meter_link_pkg::*;
#(
   parameter int WR_BYTES = 4,
   parameter int RD_BYTES = 10,
   parameter int IDXW     = 4,
   localparam int PAY_W   = (RD_BYTES-1)*8,
   localparam int SNAP_W  = RD_BYTES*8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             sda_lvl,
   input  logic             conv_done,
   input  logic [7:0]       flags,
   input  logic [PAY_W-1:0] payload,
   output logic             sda_oe,
   output logic             data_ready,
   output logic             wr_en,
   output logic [IDXW-1:0]  wr_idx,
   output logic [7:0]       wr_data,
   output logic             buzz_we,
   output logic             buzz_val
);
   link_state_t       state;
   logic [3:0]        bit_cnt;
   logic [IDXW-1:0]   byte_idx;
   logic [7:0]        shreg;
   logic [SNAP_W-1:0] snap;
   logic              rw, nack;
   logic              hdr_eval, hdr_ok, rd_accept;

   assign hdr_eval  = (state == ST_HDR) && scl_fall && (bit_cnt == 4'd8);
   assign hdr_ok    = (shreg[7:2] == HDR_CODE);
   assign rd_accept = hdr_eval && hdr_ok && shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              data_ready <= 1'b0;
      else if (conv_done)      data_ready <= 1'b1;
      else if (rd_accept)      data_ready <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         byte_idx <= '0;
         shreg    <= '0;
         snap     <= '0;
         rw       <= 1'b0;
         nack     <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
         buzz_we  <= 1'b0;
         buzz_val <= 1'b0;
      end else begin
         wr_en   <= 1'b0;
         buzz_we <= 1'b0;
         if (start_det) begin
            state   <= ST_HDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_HDR, ST_WDAT: begin
                  if (scl_rise && bit_cnt != 4'd8) begin
                     shreg   <= {shreg[6:0], sda_lvl};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (hdr_eval) begin
                     if (hdr_ok) begin
                        state    <= ST_HACK;
                        sda_oe   <= 1'b1;
                        rw       <= shreg[0];
                        buzz_we  <= 1'b1;
                        buzz_val <= shreg[1];
                        if (shreg[0]) snap <= {flags, payload};
                     end else begin
                        state <= ST_SKIP;
                     end
                  end else if (state == ST_WDAT && scl_fall && bit_cnt == 4'd8) begin
                     if (byte_idx < IDXW'(WR_BYTES)) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= byte_idx;
                        wr_data <= shreg;
                        sda_oe  <= 1'b1;
                        state   <= ST_WACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_HACK: if (scl_fall) begin
                  bit_cnt  <= '0;
                  byte_idx <= '0;
                  if (rw) begin
                     shreg  <= snap[SNAP_W-1 -: 8];
                     snap   <= snap << 8;
                     sda_oe <= ~snap[SNAP_W-1];
                     state  <= ST_RDAT;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_WDAT;
                  end
               end
               ST_WACK: if (scl_fall) begin
                  sda_oe   <= 1'b0;
                  bit_cnt  <= '0;
                  byte_idx <= byte_idx + 1'b1;
                  state    <= ST_WDAT;
               end
               ST_RDAT: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bit_cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        sda_oe <= ~shreg[6];
                        shreg  <= {shreg[6:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     nack <= sda_lvl;
                  end else if (scl_fall) begin
                     bit_cnt <= '0;
                     if (nack || byte_idx == IDXW'(RD_BYTES-1)) begin
                        state <= ST_SKIP;
                     end else begin
                        byte_idx <= byte_idx + 1'b1;
                        shreg    <= snap[SNAP_W-1 -: 8];
                        snap     <= snap << 8;
                        sda_oe   <= ~snap[SNAP_W-1];
                        state    <= ST_RDAT;
                     end
                  end
               end
               default: sda_oe <= 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/meter_link_slave.sv
module meter_link_slave #(
   parameter int SYNC_STAGES = 2,
   parameter int WR_BYTES    = 4,
   parameter int RD_BYTES    = 10,
   parameter int SLOW_W      = 19,
   parameter int FAST_W      = 10,
   parameter int AUX_W       = 19
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl,
   input  logic                  sda_in,
   output logic                  sda_oe,
   input  logic                  conv_done,
   input  logic [7:0]            res_flags,
   input  logic [SLOW_W-1:0]     res_slow,
   input  logic [FAST_W-1:0]     res_fast,
   input  logic [AUX_W-1:0]      res_aux0,
   input  logic [AUX_W-1:0]      res_aux1,
   output logic                  data_ready,
   output logic [WR_BYTES*8-1:0] ctrl_word,
   output logic                  buzz_en
);
   localparam int PAY_W = (RD_BYTES-1)*8;
   localparam int RAW_W = SLOW_W + FAST_W + 2*AUX_W;
   localparam int PAD_W = PAY_W - RAW_W;
   localparam int MAXB  = (RD_BYTES > WR_BYTES) ? RD_BYTES : WR_BYTES + 1;
   localparam int IDXW  = $clog2(MAXB + 1);

   if (RAW_W > PAY_W) begin : g_bad_fit
      $error("meter_link_slave: result words exceed the read payload");
   end
   if (WR_BYTES < 1 || RD_BYTES < 2) begin : g_bad_count
      $error("meter_link_slave: byte counts out of range");
   end

   logic [PAY_W-1:0] payload;
   if (PAD_W > 0) begin : g_pad
      assign payload = {{PAD_W{1'b0}}, res_aux1, res_aux0, res_fast, res_slow};
   end else begin : g_nopad
      assign payload = {res_aux1, res_aux0, res_fast, res_slow};
   end

   logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
   logic wr_en, buzz_we, buzz_val;
   logic [IDXW-1:0] wr_idx;
   logic [7:0] wr_data;

   meter_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_in),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl)
   );

   meter_link_fsm #(.WR_BYTES(WR_BYTES), .RD_BYTES(RD_BYTES), .IDXW(IDXW)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
      .conv_done(conv_done), .flags(res_flags), .payload(payload),
      .sda_oe(sda_oe), .data_ready(data_ready),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .buzz_we(buzz_we), .buzz_val(buzz_val)
   );

   meter_link_regs #(.NBYTES(WR_BYTES), .IDXW(IDXW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .buzz_we(buzz_we), .buzz_val(buzz_val),
      .ctrl_word(ctrl_word), .buzz_en(buzz_en)
   );
endmodule

// File: rtl/meter_link_slave_chk.sv
module meter_link_slave_chk #(
   parameter int CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl,
   input logic          sda_oe,
   input logic          conv_done,
   input logic          data_ready,
   input logic [CW-1:0] ctrl_word,
   input logic          buzz_en
);
   assert_ready_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> data_ready);

   assert_ready_clear_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_ready) |-> sda_oe);

   assert_line_moves_low_clk_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl);

   assert_cfg_moves_low_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_word) |-> !scl);

   assert_buzz_moves_low_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(buzz_en) |-> !scl);
endmodule

bind meter_link_slave meter_link_slave_chk #(.CW(WR_BYTES*8)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl(scl), .sda_oe(sda_oe),
   .conv_done(conv_done), .data_ready(data_ready),
   .ctrl_word(ctrl_word), .buzz_en(buzz_en)
);

// File: tb/meter_link_slave_test.sv
module meter_link_slave_test;
   localparam int Q = 20;

   logic        clk = 1'b0;
   logic        rst_n, scl_h, sda_h_low, conv_done;
   logic [7:0]  flags;
   logic [18:0] slow_w, aux0, aux1;
   logic [9:0]  fast_w;
   logic        sda_oe, data_ready, buzz_en;
   logic [31:0] ctrl_word;
   logic        sda_line;

   int checks = 0, errors = 0;
   bit done_flag = 0;
   logic [7:0] exp_q[$], act_q[$];

   always #4 clk = ~clk;
   assign sda_line = !(sda_h_low || sda_oe);

   meter_link_slave uut (
      .clk(clk), .rst_n(rst_n), .scl(scl_h), .sda_in(sda_line), .sda_oe(sda_oe),
      .conv_done(conv_done), .res_flags(flags), .res_slow(slow_w), .res_fast(fast_w),
      .res_aux0(aux0), .res_aux1(aux1), .data_ready(data_ready),
      .ctrl_word(ctrl_word), .buzz_en(buzz_en)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic qwait; repeat (Q) @(negedge clk); endtask

   task automatic bus_start;
      sda_h_low = 0; scl_h = 1; qwait;
      sda_h_low = 1; qwait;
      scl_h = 0; qwait;
   endtask

   task automatic bus_stop;
      sda_h_low = 1; qwait;
      scl_h = 1; qwait;
      sda_h_low = 0; qwait;
   endtask

   task automatic send_bit(input logic b);
      sda_h_low = !b; qwait;
      scl_h = 1; qwait; qwait;
      scl_h = 0; qwait;
   endtask

   task automatic recv_bit(output logic b);
      sda_h_low = 0; qwait;
      scl_h = 1; qwait;
      b = sda_line; qwait;
      scl_h = 0; qwait;
   endtask

   task automatic put_byte(input logic [7:0] v, output bit acked);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(a);
      acked = !a;
   endtask

   task automatic get_byte(output logic [7:0] v, input bit give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(!give_ack);
   endtask

   // Scoreboard driver side: expected read bytes from R9 layout
   task automatic push_expected(input int nbytes);
      logic [71:0] p;
      p = {5'b0, aux1, aux0, fast_w, slow_w};
      exp_q.push_back(flags);
      for (int k = 2; k <= nbytes; k++) exp_q.push_back(p[8*(10-k) +: 8]);
   endtask

   // Scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() != 0) begin
            logic [7:0] a, e;
            a = act_q.pop_front();
            if (exp_q.size() == 0) begin
               chk(0, "R9 unexpected read byte", {24'h0, a}, 32'h0);
            end else begin
               e = exp_q.pop_front();
               chk(a == e, "R9/R10 read byte", {24'h0, a}, {24'h0, e});
            end
         end
      end
   end

   // R12: line must not move while the clock is high
   int line_viol = 0;
   logic prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && scl_h && sda_oe !== prev_oe) line_viol++;
      prev_oe <= sda_oe;
   end

   task automatic pulse_done;
      @(negedge clk) conv_done = 1;
      @(negedge clk) conv_done = 0;
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      bit ack;
      logic [7:0] v;
      rst_n = 0; scl_h = 1; sda_h_low = 0; conv_done = 0;
      flags = 8'hA5; slow_w = 19'h5_1234; fast_w = 10'h2F1;
      aux0 = 19'h2_ABCD; aux1 = 19'h7_0F0F;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      // R1
      chk(ctrl_word == 0, "R1 ctrl_word", ctrl_word, 0);
      chk(buzz_en == 0, "R1 buzz_en", {31'h0, buzz_en}, 0);
      chk(data_ready == 0, "R1 data_ready", {31'h0, data_ready}, 0);
      chk(sda_oe == 0, "R1 sda_oe", {31'h0, sda_oe}, 0);

      // R2 R3 R4: full write with buzzer on
      bus_start();
      put_byte({6'b110010, 1'b1, 1'b0}, ack);
      chk(ack, "R2 write header ack", {31'h0, ack}, 1);
      put_byte(8'h5A, ack); chk(ack, "R3 ctrl byte1 ack", {31'h0, ack}, 1);
      put_byte(8'hC3, ack); chk(ack, "R3 ctrl byte2 ack", {31'h0, ack}, 1);
      put_byte(8'h81, ack); chk(ack, "R3 ctrl byte3 ack", {31'h0, ack}, 1);
      put_byte(8'h7E, ack); chk(ack, "R3 ctrl byte4 ack", {31'h0, ack}, 1);
      bus_stop();
      chk(ctrl_word == 32'h5AC3817E, "R3 ctrl_word", ctrl_word, 32'h5AC3817E);
      chk(buzz_en == 1, "R4 buzz on", {31'h0, buzz_en}, 1);

      // R4: header-only write clears buzzer, config kept
      bus_start();
      put_byte({6'b110010, 1'b0, 1'b0}, ack);
      bus_stop();
      chk(ack, "R4 header-only ack", {31'h0, ack}, 1);
      chk(buzz_en == 0, "R4 buzz off", {31'h0, buzz_en}, 0);
      chk(ctrl_word == 32'h5AC3817E, "R4 ctrl kept", ctrl_word, 32'h5AC3817E);

      // R5: wrong header, then ignored until next start
      bus_start();
      put_byte({6'b110011, 1'b1, 1'b0}, ack);
      chk(!ack, "R5 bad header nack", {31'h0, ack}, 0);
      put_byte({6'b110010, 1'b1, 1'b0}, ack);
      chk(!ack, "R5 ignored byte nack", {31'h0, ack}, 0);
      put_byte(8'h11, ack);
      bus_stop();
      chk(ctrl_word == 32'h5AC3817E, "R5 ctrl kept", ctrl_word, 32'h5AC3817E);
      chk(buzz_en == 0, "R5 buzz kept", {31'h0, buzz_en}, 0);

      // R7: conversion done raises ready, write keeps it
      pulse_done();
      chk(data_ready == 1, "R7 ready set", {31'h0, data_ready}, 1);

      // R6: fifth control byte refused
      bus_start();
      put_byte({6'b110010, 1'b0, 1'b0}, ack);
      put_byte(8'h01, ack);
      put_byte(8'h02, ack);
      put_byte(8'h03, ack);
      put_byte(8'h04, ack);
      put_byte(8'hEE, ack);
      chk(!ack, "R6 fifth byte nack", {31'h0, ack}, 0);
      bus_stop();
      chk(ctrl_word == 32'h01020304, "R6 ctrl_word", ctrl_word, 32'h01020304);
      chk(data_ready == 1, "R7 ready held over write", {31'h0, data_ready}, 1);

      // R8 R9 R10: full read with mid-transfer conversion
      push_expected(10);
      bus_start();
      put_byte({6'b110010, 1'b0, 1'b1}, ack);
      chk(ack, "R2 read header ack", {31'h0, ack}, 1);
      chk(data_ready == 0, "R8 ready cleared", {31'h0, data_ready}, 0);
      flags = 8'h3C; slow_w = 19'h0_0001; fast_w = 10'h001; aux0 = 19'h1; aux1 = 19'h1;
      pulse_done();
      chk(data_ready == 1, "R7 ready set during read", {31'h0, data_ready}, 1);
      for (int i = 0; i < 10; i++) begin
         get_byte(v, i != 9);
         act_q.push_back(v);
      end
      bus_stop();
      chk(sda_oe == 0, "R11 released after last byte", {31'h0, sda_oe}, 0);

      // R11: early nack, then line stays released
      slow_w = 19'h6_5432; fast_w = 10'h155; aux0 = 19'h0_7777; aux1 = 19'h3_2222;
      push_expected(3);
      bus_start();
      put_byte({6'b110010, 1'b0, 1'b1}, ack);
      chk(ack, "R2 second read header ack", {31'h0, ack}, 1);
      for (int i = 0; i < 3; i++) begin
         get_byte(v, i != 2);
         act_q.push_back(v);
      end
      get_byte(v, 1'b0);
      chk(v == 8'hFF, "R11 line released after nack", {24'h0, v}, 32'hFF);
      bus_stop();
      chk(data_ready == 0, "R8 ready low after read", {31'h0, data_ready}, 0);

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
      chk(line_viol == 0, "R12 line moved with clock high", line_viol, 0);
      finish_run();
   end
endmodule